// File: doc/BRIEF.md
# Auto-Stepping Real-Time Clock Register Port

This block gives a host a two-address window onto a set of wall-clock fields: seconds, minutes, hours, day of month, month and a 16-bit year. One address is a data register and the other a control register. A field pointer inside the block chooses which clock field the data register reaches. Every data access moves the pointer on by one field, so a host can set or fetch the whole date and time with seven back-to-back data accesses and no address arithmetic.

A write to the control address jumps the pointer straight to any field. A read of that address returns the pointer. The 16-bit year travels as two byte steps, low byte first. A one-pulse-per-second input advances the time of day. Minutes and hours are latched into a snapshot when the seconds field is read, so a tick during a read sweep cannot produce a torn time.

Top module: `rtc_field_port`

## Requirements
- R1: After reset the pointer is 0, `rd_data` is 0, and the fields hold seconds 0, minutes 0, hours 0, day 1, month 1, year 0.
- R2: The pointer encodes the fields as 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year bits 7:0, 6 year bits 15:8. A data read returns the field that the pointer selects.
- R3: Each data read or data write (`acc_sel`=0) advances the pointer by one. From 6 the pointer goes to 0, and it never holds a value above 6.
- R4: A control write (`acc_sel`=1) of a value from 0 to 6 loads the pointer. A control read returns the pointer in bits 2:0 with bits 7:3 zero, and it leaves the pointer unchanged.
- R5: A control write of a value above 6 leaves the pointer unchanged.
- R6: A write at step 5 sets the year to the written byte with the upper byte zero. A write at step 6 adds the byte times 256 to the stored year, so low 227 followed by high 7 gives 2019.
- R7: A `sec_tick` pulse advances seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 (24-hour form). Day, month and year change only through host writes.
- R8: A read of minutes or hours returns the value captured at the most recent seconds read or control write, or written since then. A tick between the capture and the read does not change the returned value.
- R9: `rd_data` is registered. It shows the result of a read after the clock edge that samples `acc_rd`, and it holds that value until the next read.
- R10: A host write to seconds, minutes or hours in the same cycle as a tick stores the written value in that field. A written seconds field produces no carry in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| acc_sel | input | 1 | Selects the address: 0 for data, 1 for control |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_rd | input | 1 | Read strobe, one cycle per access. It is ignored when `acc_wr` is also high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
Every read result appears on `rd_data` at the rising edge that samples the strobe. Pointer moves, field writes and tick effects are visible on the next access. The bench drives each one-cycle strobe from the falling edge. A monitor records at the rising edge that a read was taken, and compares `rd_data` against the head of the expected queue at the following falling edge, exactly one cycle after the stimulus. The bench model updates its pointer, snapshot and tick state in the same order as the RTL. Expected values are pushed before the access starts, so they reflect the state that the access sees.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned YEAR_W     = 2 * BYTE_W;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned FIELD_W    = $clog2(NUM_FIELDS);

  typedef enum logic [FIELD_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DAY  = 3'd3,
    F_MON  = 3'd4,
    F_YLO  = 3'd5,
    F_YHI  = 3'd6
  } field_e;

  // next field in the fixed walk, wrapping after the last one
  function automatic field_e field_after(input field_e f);
    if (f == F_YHI) return F_SEC;
    return field_e'(f + 3'd1);
  endfunction

  // a control value is usable only when it names a real field
  function automatic logic field_ok(input logic [BYTE_W-1:0] v);
    return 32'(v) < NUM_FIELDS;
  endfunction

  // increment modulo lim, result {carry, value}
  function automatic logic [BYTE_W:0] step_mod(input logic [BYTE_W-1:0] v,
                                               input int unsigned lim);
    if (32'(v) >= lim - 1) return {1'b1, {BYTE_W{1'b0}}};
    return {1'b0, v + 8'd1};
  endfunction
endpackage

// File: rtl/rtc_field_ptr.sv
module rtc_field_ptr
  import rtc_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output field_e            ptr
);
  logic load_ok;
  assign load_ok = load && field_ok(load_val);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= F_SEC;
    else if (load_ok) ptr <= field_e'(load_val[FIELD_W-1:0]);
    else if (step)    ptr <= field_after(ptr);
  end

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= F_YHI);
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == F_YHI) |=> (ptr == F_SEC));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr != F_YHI) |=> (3'(ptr) == 3'($past(ptr)) + 3'd1));
  p_bad_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step && !field_ok(load_val)) |=> $stable(ptr));
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_port_pkg::*;
#(
  parameter int unsigned SEC_LIM  = 60,
  parameter int unsigned MIN_LIM  = 60,
  parameter int unsigned HOUR_LIM = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  field_e            wr_field,
  input  logic [BYTE_W-1:0] wr_val,
  output logic [BYTE_W-1:0] sec,
  output logic [BYTE_W-1:0] min,
  output logic [BYTE_W-1:0] hour
);
  logic              wr_sec, wr_min, wr_hour;
  logic              sec_wrap, min_wrap;
  logic [BYTE_W:0]   sec_nx, min_nx, hour_nx;

  assign wr_sec  = wr_en && wr_field == F_SEC;
  assign wr_min  = wr_en && wr_field == F_MIN;
  assign wr_hour = wr_en && wr_field == F_HOUR;

  assign sec_nx   = step_mod(sec,  SEC_LIM);
  assign min_nx   = step_mod(min,  MIN_LIM);
  assign hour_nx  = step_mod(hour, HOUR_LIM);
  // carry events as named wires
  assign sec_wrap = tick && !wr_sec && sec_nx[BYTE_W];
  assign min_wrap = sec_wrap && !wr_min && min_nx[BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else begin
      if (wr_sec)        sec  <= wr_val;
      else if (tick)     sec  <= sec_nx[BYTE_W-1:0];
      if (wr_min)        min  <= wr_val;
      else if (sec_wrap) min  <= min_nx[BYTE_W-1:0];
      if (wr_hour)       hour <= wr_val;
      else if (min_wrap) hour <= hour_nx[BYTE_W-1:0];
    end
  end

  p_sec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_sec && sec == 8'(SEC_LIM - 1)) |=> (sec == '0));
  p_hour_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec == 8'(SEC_LIM - 1) && min == 8'(MIN_LIM - 1)
     && hour == 8'(HOUR_LIM - 1)) |=> (hour == '0 && min == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour)));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec == $past(wr_val)));
endmodule

// File: rtl/rtc_date_regs.sv
module rtc_date_regs
  import rtc_port_pkg::*;
#(
  parameter int unsigned RESET_DAY  = 1,
  parameter int unsigned RESET_MON  = 1,
  parameter int unsigned RESET_YEAR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  field_e            wr_field,
  input  logic [BYTE_W-1:0] wr_val,
  output logic [BYTE_W-1:0] day,
  output logic [BYTE_W-1:0] mon,
  output logic [YEAR_W-1:0] year
);
  logic wr_ylo, wr_yhi;
  assign wr_ylo = wr_en && wr_field == F_YLO;
  assign wr_yhi = wr_en && wr_field == F_YHI;

  // high step accumulates onto the stored year
  function automatic logic [YEAR_W-1:0] year_add_hi(input logic [YEAR_W-1:0] y,
                                                    input logic [BYTE_W-1:0] hi);
    return y + {hi, {BYTE_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day  <= BYTE_W'(RESET_DAY);
      mon  <= BYTE_W'(RESET_MON);
      year <= YEAR_W'(RESET_YEAR);
    end else if (wr_en) begin
      case (wr_field)
        F_DAY:   day  <= wr_val;
        F_MON:   mon  <= wr_val;
        F_YLO:   year <= {{BYTE_W{1'b0}}, wr_val};
        F_YHI:   year <= year_add_hi(year, wr_val);
        default: ;
      endcase
    end
  end

  p_ylo_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ylo |=> (year == {8'h00, $past(wr_val)}));
  p_yhi_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_yhi |=> (year[BYTE_W-1:0] == $past(year[BYTE_W-1:0])));
  p_date_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(day) && $stable(mon) && $stable(year)));
endmodule

// File: rtl/rtc_field_port.sv
module rtc_field_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned SEC_LIM    = 60,
  parameter int unsigned MIN_LIM    = 60,
  parameter int unsigned HOUR_LIM   = 24,
  parameter int unsigned RESET_DAY  = 1,
  parameter int unsigned RESET_MON  = 1,
  parameter int unsigned RESET_YEAR = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       acc_sel,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  // decoded access events (write wins over read)
  logic data_rd, data_wr, ctrl_rd, ctrl_wr, snap_take;
  assign data_wr = acc_wr && !acc_sel;
  assign ctrl_wr = acc_wr &&  acc_sel;
  assign data_rd = acc_rd && !acc_wr && !acc_sel;
  assign ctrl_rd = acc_rd && !acc_wr &&  acc_sel;

  field_e            ptr;
  logic [BYTE_W-1:0] sec, min, hour, day, mon;
  logic [YEAR_W-1:0] year;
  logic [BYTE_W-1:0] snap_min, snap_hour;

  assign snap_take = ctrl_wr || (data_rd && ptr == F_SEC);

  rtc_field_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (data_rd || data_wr),
    .load     (ctrl_wr),
    .load_val (wr_data),
    .ptr      (ptr)
  );

  rtc_time_counter #(
    .SEC_LIM  (SEC_LIM),
    .MIN_LIM  (MIN_LIM),
    .HOUR_LIM (HOUR_LIM)
  ) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .wr_en    (data_wr),
    .wr_field (ptr),
    .wr_val   (wr_data),
    .sec      (sec),
    .min      (min),
    .hour     (hour)
  );

  rtc_date_regs #(
    .RESET_DAY  (RESET_DAY),
    .RESET_MON  (RESET_MON),
    .RESET_YEAR (RESET_YEAR)
  ) u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr),
    .wr_field (ptr),
    .wr_val   (wr_data),
    .day      (day),
    .mon      (mon),
    .year     (year)
  );

  // snapshot of the fields a tick can move under a read sweep
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_min  <= '0;
      snap_hour <= '0;
    end else if (snap_take) begin
      snap_min  <= min;
      snap_hour <= hour;
    end else if (data_wr) begin
      if (ptr == F_MIN)  snap_min  <= wr_data;
      if (ptr == F_HOUR) snap_hour <= wr_data;
    end
  end

  function automatic logic [BYTE_W-1:0] pick_field(
    input field_e f, input logic [BYTE_W-1:0] s, input logic [BYTE_W-1:0] m,
    input logic [BYTE_W-1:0] h, input logic [BYTE_W-1:0] d,
    input logic [BYTE_W-1:0] mo, input logic [YEAR_W-1:0] y);
    case (f)
      F_SEC:   return s;
      F_MIN:   return m;
      F_HOUR:  return h;
      F_DAY:   return d;
      F_MON:   return mo;
      F_YLO:   return y[BYTE_W-1:0];
      default: return y[YEAR_W-1:BYTE_W];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (data_rd) rd_data <= pick_field(ptr, sec, snap_min, snap_hour, day, mon, year);
    else if (ctrl_rd) rd_data <= {{(BYTE_W-FIELD_W){1'b0}}, ptr};
  end

  p_ctrl_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (rd_data == {5'b0, 3'($past(ptr))}));
  p_ctrl_rd_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !sec_tick) |=> $stable(ptr));
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_take && !data_wr) |=> ($stable(snap_min) && $stable(snap_hour)));
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rd_data));
endmodule

// File: tb/test_rtc_field_port.sv
`timescale 1ns/1ps
module test_rtc_field_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       acc_sel = 1'b0;
  logic       acc_wr = 1'b0;
  logic       acc_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  rtc_field_port i_rtc_field_port (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .acc_sel(acc_sel),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .wr_data(wr_data), .rd_data(rd_data)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model of the clock state
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_mon = 1, m_year = 0;
  int m_ptr = 0, s_min = 0, s_hr = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: a read taken at a rising edge is compared at the next falling edge
  logic pend = 1'b0;
  always @(posedge clk) pend <= acc_rd && !acc_wr && rst_n;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 actual=%0d expected=<no read queued>", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic strobe(input logic sel, input logic wr, input logic rd,
                        input logic [7:0] d, input logic tk);
    @(negedge clk);
    acc_sel = sel; acc_wr = wr; acc_rd = rd; wr_data = d; sec_tick = tk;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0; sec_tick = 1'b0;
  endtask

  // model tick; skip names a field the host writes in the same cycle (-1 none)
  task automatic m_tick(input int skip);
    bit c1 = 0, c2 = 0;
    if (skip != 0) begin
      if (m_sec >= 59) begin m_sec = 0; c1 = 1; end else m_sec++;
    end
    if (c1 && skip != 1) begin
      if (m_min >= 59) begin m_min = 0; c2 = 1; end else m_min++;
    end
    if (c2 && skip != 2) m_hr = (m_hr >= 23) ? 0 : m_hr + 1;
  endtask

  function automatic int m_field(input int f);
    case (f)
      0: return m_sec;
      1: return s_min;
      2: return s_hr;
      3: return m_day;
      4: return m_mon;
      5: return m_year & 255;
      default: return (m_year >> 8) & 255;
    endcase
  endfunction

  task automatic rd_field(input string tag, input logic tk = 1'b0);
    if (m_ptr == 0) begin s_min = m_min; s_hr = m_hr; end
    exp_q.push_back(8'(m_field(m_ptr))); tag_q.push_back(tag);
    strobe(1'b0, 1'b0, 1'b1, 8'h00, tk);
    if (tk) m_tick(-1);
    m_ptr = (m_ptr == 6) ? 0 : m_ptr + 1;
  endtask

  task automatic wr_field(input int v, input logic tk = 1'b0);
    if (tk) m_tick(m_ptr);
    case (m_ptr)
      0: m_sec = v;
      1: begin m_min = v; s_min = v; end
      2: begin m_hr = v; s_hr = v; end
      3: m_day = v;
      4: m_mon = v;
      5: m_year = v;
      default: m_year = (m_year + v * 256) & 16'hffff;
    endcase
    strobe(1'b0, 1'b1, 1'b0, 8'(v), tk);
    m_ptr = (m_ptr == 6) ? 0 : m_ptr + 1;
  endtask

  task automatic wr_ctrl(input int v);
    s_min = m_min; s_hr = m_hr;
    if (v <= 6) m_ptr = v;
    strobe(1'b1, 1'b1, 1'b0, 8'(v), 1'b0);
  endtask

  task automatic rd_ctrl(input string tag);
    exp_q.push_back(8'(m_ptr)); tag_q.push_back(tag);
    strobe(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      strobe(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      m_tick(-1);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<finish>", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd_ctrl("R1 pointer after reset");
    for (int f = 0; f < 7; f++) rd_field("R1 R2 reset field");
    rd_ctrl("R3 wrap after seven reads");

    // full set sequence, year 2019
    wr_ctrl(0);
    wr_field(1); wr_field(35); wr_field(8); wr_field(25);
    wr_field(10); wr_field(227); wr_field(7);
    rd_ctrl("R3 wrap after seven writes");
    for (int f = 0; f < 7; f++) rd_field("R2 R6 field after set");

    // jumps and bad loads
    wr_ctrl(5);
    rd_ctrl("R4 control load 5");
    rd_ctrl("R4 control read keeps pointer");
    rd_field("R6 year low"); rd_field("R6 year high");
    rd_ctrl("R3 wrap from year high");
    wr_ctrl(3);
    wr_ctrl(7);
    rd_ctrl("R5 value 7 ignored");
    wr_ctrl(200);
    rd_ctrl("R5 value 200 ignored");

    // year high accumulates
    wr_ctrl(5); wr_field(8'h10); wr_field(1);
    wr_ctrl(6); wr_field(2);
    wr_ctrl(5);
    rd_field("R6 low kept 0x10"); rd_field("R6 high accumulated 3");

    // rollover of the full time of day
    wr_ctrl(0); wr_field(59); wr_field(59); wr_field(23);
    tick_n(1);
    wr_ctrl(0);
    for (int f = 0; f < 4; f++) rd_field("R7 rollover to midnight");

    // long run: 3725 ticks
    tick_n(3725);
    wr_ctrl(0);
    for (int f = 0; f < 3; f++) rd_field("R7 count after 3725 ticks");

    // snapshot across a tick
    wr_ctrl(0); wr_field(59); wr_field(10); wr_field(5);
    wr_ctrl(0);
    rd_field("R8 seconds read takes snapshot");
    tick_n(1);
    rd_field("R8 minutes from snapshot");
    rd_field("R8 hours from snapshot");
    wr_ctrl(1);
    rd_field("R8 control write retakes snapshot");

    // write in the same cycle as a tick
    wr_ctrl(0); wr_field(20, 1'b1);
    wr_ctrl(0); rd_field("R10 seconds write beats tick");
    wr_ctrl(0); wr_field(59);
    wr_ctrl(1); wr_field(7, 1'b1);
    wr_ctrl(0);
    rd_field("R10 seconds wrapped"); rd_field("R10 minutes write beats carry");

    // read data holds
    wr_ctrl(3);
    rd_field("R9 day read");
    repeat (2) @(negedge clk);
    held = 8'(m_day);
    check("R9 rd_data holds when idle", rd_data, held);
    tick_n(2);
    wr_field(12);
    check("R9 rd_data holds across write and tick", rd_data, held);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 actual=%0d expected=0 (reads never returned)", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule